// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupts

This block is a register-mapped general-purpose pin controller for up to `PINS` pins. Software reads the synchronized pin levels and sets an output value and an output enable for each pin. Each pin also has two interrupt sources that work at the same time: a level source and an edge source. Each source has its own polarity or edge-select register and its own enable register. A detected edge sets a sticky flag, and software clears that flag by writing a one to it.

The pending conditions of all pins are ORed into one summary bit. A top-level mask bit gates this summary bit onto the registered `irq_o` line. The register port is a plain synchronous port. It accepts a request on every cycle in which `bus_en` is high and never applies back-pressure. Read data comes back one cycle after the request, qualified by `bus_rvalid`. Pad drivers and pin muxing are outside the block.

Register map (byte offsets on `bus_addr`): 0x00 synchronized pin input (read-only), 0x04 output value, 0x08 output enable, 0x0C level polarity, 0x10 level enable, 0x14 edge select, 0x18 edge flags (write one to clear), 0x1C edge enable, 0x20 summary status (read-only, bit 0), 0x24 summary mask (bit 0).

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` and `pad_out` are 0 and `irq_o` is 0.
- R2: `pad_in` passes through two flops before it reaches the input register at 0x00 and the edge detectors. A read issued on cycle N returns the register value held at edge N on `bus_rdata`, with `bus_rvalid` high in the cycle after the request.
- R3: `pad_oe` equals the enable register at 0x08. `pad_out` carries the value register at 0x04 only on pins whose enable bit is 1, and 0 elsewhere.
- R4: A pin's level source is pending when (synchronized input XOR polarity bit at 0x0C) AND enable bit at 0x10 is 1. Polarity 0 means active-high and polarity 1 means active-low.
- R5: The edge-select bit at 0x14 picks the edge that sets the pin's flag at 0x18: 0 selects rising, 1 selects falling. The flag stays set after the pin level changes back.
- R6: Writing 1 to a bit of 0x18 clears that flag. Writing 0 leaves it unchanged.
- R7: When a new edge and a clear hit the same flag in the same cycle, the flag ends up set.
- R8: A pin's edge source is pending when its flag AND its enable bit at 0x1C are both 1. Bit 0 of 0x20 reads 1 when any pin has a pending level or edge source.
- R9: `irq_o` is registered and is 1 one cycle after a cycle in which the summary is pending and bit 0 of 0x24 is 1.
- R10: A read from an offset that is not in the map returns 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data returned this cycle |
| pad_in | input | PINS | Asynchronous pin levels |
| pad_out | output | PINS | Output value, gated by enable |
| pad_oe | output | PINS | Per-pin output enable |
| irq_o | output | 1 | Summary interrupt line |

## Verification
A change on `pad_in` appears in the input register two edges after it is driven. A level-driven `irq_o` rises on the third edge, and an edge flag is set on the third edge, so the edge-driven `irq_o` rises on the fourth. Register writes affect `pad_out`/`pad_oe` at the write edge, and a mask write affects `irq_o` one edge later. Read data belongs to the edge that accepted the request. The bench's reference model advances at every rising edge using the inputs that were stable across it. Outputs are compared at the following falling edge, and the directed checks count these same edge distances before sampling.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_PIN_IN    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_OUT_VAL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_OUT_EN    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_LVL_POL   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_LVL_EN    = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_EDGE_SEL  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_EDGE_FLAG = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_EDGE_EN   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_SUM_STAT  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_SUM_MASK  = 8'h24;

  localparam int SUMMARY_BIT = 0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_src.sv
module gpio_irq_src #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] lvl_pol,
  input  logic [W-1:0] lvl_en,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] edge_en,
  input  logic [W-1:0] flag_clr,
  output logic [W-1:0] flags,
  output logic [W-1:0] det,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_sync;
  end

  assign rise = pin_sync & ~prev_q;
  assign fall = ~pin_sync & prev_q;
  assign det  = (rise & ~edge_sel) | (fall & edge_sel);

  // a fresh edge survives a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | det;
  end

  assign pend = ((pin_sync ^ lvl_pol) & lvl_en) | (flags & edge_en);
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int BUS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  output logic                bus_rvalid,
  input  logic [PINS-1:0]     pad_in,
  output logic [PINS-1:0]     pad_out,
  output logic [PINS-1:0]     pad_oe,
  output logic                irq_o
);
  logic [PINS-1:0] out_val_q, out_en_q, lvl_pol_q, lvl_en_q, edge_sel_q, edge_en_q;
  logic            sum_mask_q;
  logic [PINS-1:0] pin_sync, edge_flags, det_vec, pend_vec, clr_vec;
  logic            any_pend;
  logic            wr_req, rd_req;
  logic [PINS-1:0] wval;
  logic [BUS_W-1:0] rd_word;

  assign wr_req = bus_en & bus_we;
  assign rd_req = bus_en & ~bus_we;
  assign wval   = bus_wdata[PINS-1:0];

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pad_in),
    .dout (pin_sync)
  );

  assign clr_vec = (wr_req && bus_addr == OFF_EDGE_FLAG) ? wval : '0;

  gpio_irq_src #(.W(PINS)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_sync(pin_sync),
    .lvl_pol (lvl_pol_q),
    .lvl_en  (lvl_en_q),
    .edge_sel(edge_sel_q),
    .edge_en (edge_en_q),
    .flag_clr(clr_vec),
    .flags   (edge_flags),
    .det     (det_vec),
    .pend    (pend_vec)
  );

  assign any_pend = |pend_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_val_q  <= '0;
      out_en_q   <= '0;
      lvl_pol_q  <= '0;
      lvl_en_q   <= '0;
      edge_sel_q <= '0;
      edge_en_q  <= '0;
      sum_mask_q <= 1'b0;
    end else if (wr_req) begin
      case (bus_addr)
        OFF_OUT_VAL:  out_val_q  <= wval;
        OFF_OUT_EN:   out_en_q   <= wval;
        OFF_LVL_POL:  lvl_pol_q  <= wval;
        OFF_LVL_EN:   lvl_en_q   <= wval;
        OFF_EDGE_SEL: edge_sel_q <= wval;
        OFF_EDGE_EN:  edge_en_q  <= wval;
        OFF_SUM_MASK: sum_mask_q <= bus_wdata[SUMMARY_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      OFF_PIN_IN:    rd_word[PINS-1:0] = pin_sync;
      OFF_OUT_VAL:   rd_word[PINS-1:0] = out_val_q;
      OFF_OUT_EN:    rd_word[PINS-1:0] = out_en_q;
      OFF_LVL_POL:   rd_word[PINS-1:0] = lvl_pol_q;
      OFF_LVL_EN:    rd_word[PINS-1:0] = lvl_en_q;
      OFF_EDGE_SEL:  rd_word[PINS-1:0] = edge_sel_q;
      OFF_EDGE_FLAG: rd_word[PINS-1:0] = edge_flags;
      OFF_EDGE_EN:   rd_word[PINS-1:0] = edge_en_q;
      OFF_SUM_STAT:  rd_word[SUMMARY_BIT] = any_pend;
      OFF_SUM_MASK:  rd_word[SUMMARY_BIT] = sum_mask_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_word;
      irq_o <= any_pend & sum_mask_q;
    end
  end

  assign pad_oe  = out_en_q;
  assign pad_out = out_val_q & out_en_q;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_en,
  input logic            bus_we,
  input logic            rvalid,
  input logic            irq,
  input logic            sum_mask,
  input logic            any_pend,
  input logic [PINS-1:0] flags,
  input logic [PINS-1:0] det,
  input logic [PINS-1:0] clr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !irq);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(sum_mask));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(any_pend));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~flags & ~$past(clr)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(det) & ~flags) == '0));

  // R2
  read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(bus_en && !bus_we));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.PINS(PINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_en  (bus_en),
  .bus_we  (bus_we),
  .rvalid  (bus_rvalid),
  .irq     (irq_o),
  .sum_mask(sum_mask_q),
  .any_pend(any_pend),
  .flags   (edge_flags),
  .det     (det_vec),
  .clr     (clr_vec)
);

// File: tb/tb_gpio_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_ctrl;
  localparam int PINS = 32;
  localparam int BW   = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [BW-1:0]   bus_wdata = '0;
  logic [BW-1:0]   bus_rdata;
  logic            bus_rvalid;
  logic [PINS-1:0] pad_in = '0;
  logic [PINS-1:0] pad_out, pad_oe;
  logic            irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_ctrl #(.PINS(PINS), .BUS_W(BW)) dut (.*);

  // behavioural reference state
  logic [31:0] m_s1, m_s2, m_prv, m_val, m_oen, m_lpol, m_len, m_esel, m_flag, m_een, m_rdata;
  logic        m_mask, m_irq, m_rvalid;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_s1, m_s2, m_prv, m_val, m_oen, m_lpol, m_len, m_esel, m_flag, m_een, m_rdata} = '0;
    {m_mask, m_irq, m_rvalid} = '0;
  endtask

  function automatic logic [31:0] model_read(logic [7:0] a, logic [31:0] pend);
    case (a)
      8'h00: return m_s2;
      8'h04: return m_val;
      8'h08: return m_oen;
      8'h0C: return m_lpol;
      8'h10: return m_len;
      8'h14: return m_esel;
      8'h18: return m_flag;
      8'h1C: return m_een;
      8'h20: return {31'd0, pend != 0};
      8'h24: return {31'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  task automatic step();
    logic [31:0] det, pend, clr;
    logic wr, rd;
    @(posedge clk);
    if (rst_n) begin
      det  = (m_s2 & ~m_prv & ~m_esel) | (~m_s2 & m_prv & m_esel);
      pend = ((m_s2 ^ m_lpol) & m_len) | (m_flag & m_een);
      wr = bus_en && bus_we;
      rd = bus_en && !bus_we;
      if (rd) m_rdata = model_read(bus_addr, pend);
      m_rvalid = rd;
      clr = (wr && bus_addr == 8'h18) ? bus_wdata : 32'd0;
      m_irq = (pend != 0) && m_mask;
      m_flag = (m_flag & ~clr) | det;
      if (wr) case (bus_addr)
        8'h04: m_val  = bus_wdata;
        8'h08: m_oen  = bus_wdata;
        8'h0C: m_lpol = bus_wdata;
        8'h10: m_len  = bus_wdata;
        8'h14: m_esel = bus_wdata;
        8'h1C: m_een  = bus_wdata;
        8'h24: m_mask = bus_wdata[0];
        default: ;
      endcase
      m_prv = m_s2; m_s2 = m_s1; m_s1 = pad_in;
    end
    @(negedge clk);
    chk("R3 pad_oe", pad_oe, m_oen);
    chk("R3 pad_out", pad_out, m_val & m_oen);
    chk("R9 irq model", {31'd0, irq_o}, {31'd0, m_irq});
    chk("R2 rvalid model", {31'd0, bus_rvalid}, {31'd0, m_rvalid});
    if (bus_rvalid) chk("R2 rdata model", bus_rdata, m_rdata);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_en = 1; bus_we = 0; bus_addr = a;
    step();
    bus_en = 0;
    v = bus_rdata;
  endtask

  task automatic rd_exp(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 irq reset", {31'd0, irq_o}, 32'd0);
    chk("R1 pad_oe reset", pad_oe, 32'd0);
    rst_n = 1;
    // R1: every register reads zero
    for (int a = 0; a <= 8'h24; a += 4) rd_exp("R1 reset read", 8'(a), 32'd0);

    // R3 output gating
    wr(8'h04, 32'hA5A5_0F0F);
    wr(8'h08, 32'h0000_FFFF);
    chk("R3 oe", pad_oe, 32'h0000_FFFF);
    chk("R3 out gated", pad_out, 32'h0000_0F0F);
    wr(8'h08, 32'h0);
    chk("R3 out disabled", pad_out, 32'h0);

    // R2 two-flop synchronizer latency
    pad_in = 32'h1234_5678;
    rd_exp("R2 sync edge1", 8'h00, 32'h0);
    rd_exp("R2 sync edge2", 8'h00, 32'h0);
    rd_exp("R2 sync edge3", 8'h00, 32'h1234_5678);
    idle(2);
    rd_exp("R5 rising flags", 8'h18, 32'h1234_5678);
    pad_in = 32'h0;
    idle(4);
    wr(8'h18, 32'hFFFF_FFFF);
    rd_exp("R6 clear all", 8'h18, 32'h0);

    // R4 level sources
    wr(8'h24, 32'h1);
    wr(8'h10, 32'h8);
    pad_in = 32'h8;
    step(); step();
    chk("R4 irq not yet", {31'd0, irq_o}, 32'd0);
    step();
    chk("R4 irq on third edge", {31'd0, irq_o}, 32'd1);
    rd_exp("R8 status level", 8'h20, 32'h1);
    wr(8'h0C, 32'h8);
    rd_exp("R4 active-low idle", 8'h20, 32'h0);
    pad_in = 32'h0;
    idle(3);
    rd_exp("R4 active-low pend", 8'h20, 32'h1);
    wr(8'h10, 32'h0);
    wr(8'h0C, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd_exp("R8 status clear", 8'h20, 32'h0);

    // R5 edge select
    wr(8'h1C, 32'h60);
    wr(8'h14, 32'h40);
    pad_in = 32'h20;
    idle(4);
    rd_exp("R5 rising bit5", 8'h18, 32'h20);
    pad_in = 32'h60;
    idle(4);
    rd_exp("R5 falling-select ignores rise", 8'h18, 32'h20);
    rd_exp("R8 status edge", 8'h20, 32'h1);
    pad_in = 32'h0;
    idle(4);
    rd_exp("R5 falling bit6, bit5 sticky", 8'h18, 32'h60);

    // R6 write-one-to-clear
    wr(8'h18, 32'h0);
    rd_exp("R6 zero write no effect", 8'h18, 32'h60);
    wr(8'h18, 32'h20);
    rd_exp("R6 clear one bit", 8'h18, 32'h40);

    // R8 edge enable mask
    wr(8'h1C, 32'h0);
    rd_exp("R8 masked flag", 8'h20, 32'h0);
    rd_exp("R8 flag kept", 8'h18, 32'h40);
    wr(8'h18, 32'h40);

    // R7 set beats clear
    wr(8'h1C, 32'h80);
    pad_in = 32'h80;
    step(); step();
    wr(8'h18, 32'h80);
    rd_exp("R7 set wins", 8'h18, 32'h80);
    rd_exp("R8 status set", 8'h20, 32'h1);

    // R9 summary mask timing
    wr(8'h24, 32'h0);
    chk("R9 mask lag", {31'd0, irq_o}, 32'd1);
    step();
    chk("R9 masked", {31'd0, irq_o}, 32'd0);
    wr(8'h24, 32'h1);
    chk("R9 unmask lag", {31'd0, irq_o}, 32'd0);
    step();
    chk("R9 unmasked", {31'd0, irq_o}, 32'd1);

    // R10 unmapped offsets
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd_exp("R10 read 0x28", 8'h28, 32'h0);
    rd_exp("R10 read 0x05", 8'h05, 32'h0);
    rd_exp("R10 out untouched", 8'h04, 32'hA5A5_0F0F);
    rd_exp("R10 oe untouched", 8'h08, 32'h0);
    rd_exp("R10 mask untouched", 8'h24, 32'h1);
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule